// File: doc/BRIEF.md
# Instruction Class Decoder Stage

This block is the decode stage of a pipeline for a 32-bit load/store instruction set with conditional execution. When the fetch side offers an instruction word that is valid and not stalled, the block latches the word and its address into a stage register. For that one cycle it raises a new-instruction strobe. Everything downstream reads the latched word, so a stalled pipeline keeps showing the same decode.

From the latched word the block derives the instruction class, a compact mnemonic index, the condition code, the register numbers and the expanded rotated immediate. It also produces a shift description with the zero-amount special cases folded in, a branch target relative to the current program counter, and the transfer direction, width and block addressing mode. Register reads, execution, coprocessor work and exception handling are left to other stages.

Top module: `insn_class_decoder`

## Requirements
- R1: When `rst` is low, `valid_i` is high and `stall_i` is low at a rising edge, `insn_o` and `iaddr_o` take `insn_i` and `addr_i`, and `new_insn_o` is high for exactly the following cycle. Every accepted word yields one strobe.
- R2: A rising edge with `stall_i` high or `valid_i` low captures nothing. At such an edge `new_insn_o` goes low, and `insn_o` and `iaddr_o` keep their previous values.
- R3: A rising edge with `rst` high (synchronous, active high) clears `insn_o` and `iaddr_o` to zero and drives `new_insn_o` low.
- R4: `class_o` is assigned by the first matching rule in this order: swap=2, multiply=1, data-processing (bits 27:26 = 00) = 0, single transfer (01) = 3, block transfer (bits 27:25 = 100) = 4, branch (101) = 5, coprocessor transfer (110) = 6, coprocessor data op (bits 27:24 = 1110 and bit 4 = 0) = 7, coprocessor register move (1110 and bit 4 = 1) = 8, and otherwise software trap = 9.
- R5: Swap means bits 27:23 = 00010, bits 21:20 = 00 and bits 11:4 = 0x09. Multiply means bits 27:22 = 0 and bits 7:4 = 1001. Both win over data-processing; a word that misses the swap pattern only in bits 21:20 decodes as data-processing.
- R6: `mnem_o` follows the class:
  - data-processing: the opcode in bits 24:21, giving 0 to 15;
  - multiply: mul 16, mla 17, chosen by bit 21;
  - swap: word 18, byte 19, chosen by bit 22;
  - single transfer: 20 + 2·bit20 + bit22 (str, strb, ldr, ldrb);
  - block transfer: store 24, load 25;
  - branch: plain 26, with link 27, chosen by bit 24;
  - coprocessor transfer: stc 28, ldc 29;
  - coprocessor data op: 30;
  - coprocessor register move: 31 for bit 20 = 0, 32 for bit 20 = 1;
  - software trap: 33.
- R7: The field outputs are `cond_o` = bits 31:28, `opcode_o` = 24:21, `sflag_o` = bit 20, `rn_o` = 19:16, `rd_o` = 15:12, `rs_o` = 11:8 and `rm_o` = 3:0. `cond_always_o` is high exactly when the condition is 0xE.
- R8: `imm_valid_o` is high only for data-processing words with bit 25 set. `imm_o` is then bits 7:0 rotated right by twice bits 11:8; otherwise it is zero.
- R9: `shift_kind_o` is non-zero only for data-processing words with bit 25 clear, using the codes none 0, LSL 1, LSR 2, ASR 3, ROR 4, RRX 5 and by-register 6. Bit 4 set gives by-register. Otherwise bits 6:5 pick LSL, LSR, ASR or ROR with the amount in bits 11:7, where LSL by 0 is none and ROR by 0 is RRX. `shift_amt_o` carries the amount only for LSL, LSR, ASR and ROR, and is zero otherwise.
- R10: For a branch, `branch_target_o` = `pc_i` + (sign-extended bits 23:0 × 4) and `branch_link_o` = bit 24. For all other classes both are zero.
- R11: `writes_rd_o` is high for data-processing except opcodes 8 to 11 (the compares). `uses_rn_o` is high for data-processing except opcodes 13 and 15 (the moves). Both are low for other classes.
- R12: `xfer_byte_o` is bit 22 for a single transfer and zero otherwise. `xfer_load_o` is bit 20 for single and block transfers and zero otherwise. `block_mode_o` is bits 24:23 for a block transfer (0 decrement-after, 1 increment-after, 2 decrement-before, 3 increment-before) and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Fetch stall; blocks capture |
| valid_i | input | 1 | Offered word is valid |
| insn_i | input | 32 | Offered instruction word |
| addr_i | input | ADDR_W | Address of the offered word |
| pc_i | input | ADDR_W | Current program counter for branch targets |
| new_insn_o | output | 1 | One-cycle strobe after a capture |
| insn_o | output | 32 | Latched instruction word |
| iaddr_o | output | ADDR_W | Latched instruction address |
| class_o | output | 4 | Instruction class code |
| mnem_o | output | 6 | Mnemonic index |
| cond_o | output | 4 | Condition field |
| cond_always_o | output | 1 | Condition is unconditional |
| opcode_o | output | 4 | Data-processing opcode field |
| sflag_o | output | 1 | Flag-update bit |
| rn_o | output | 4 | First operand register |
| rd_o | output | 4 | Destination register |
| rs_o | output | 4 | Shift register / rotate field |
| rm_o | output | 4 | Second operand register |
| writes_rd_o | output | 1 | Data op writes a destination |
| uses_rn_o | output | 1 | Data op reads the first operand |
| imm_valid_o | output | 1 | Rotated immediate in use |
| imm_o | output | 32 | Expanded immediate |
| shift_kind_o | output | 3 | Shift kind code |
| shift_amt_o | output | 5 | Immediate shift amount |
| branch_link_o | output | 1 | Branch saves return address |
| branch_target_o | output | ADDR_W | Branch destination |
| xfer_byte_o | output | 1 | Single transfer is byte wide |
| xfer_load_o | output | 1 | Transfer is a load |
| block_mode_o | output | 2 | Block addressing mode |

## Verification
Two things can meet in one cycle here: the strobe and decode of a just-accepted word, and a fresh offer that arrives with the stall raised or the valid flag dropped. The bench offers words back to back with stall and valid toggled from a pseudo-random stream, so that accepts and refusals land in adjacent cycles. A monitor pairs each strobe with the oldest accepted word and compares every decoded field. Directed refusals check that the strobe falls and the latched word stays put right after a capture.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

  localparam int INSN_W = 32;

  typedef enum logic [3:0] {
    CLS_DATA   = 4'd0,
    CLS_MUL    = 4'd1,
    CLS_SWAP   = 4'd2,
    CLS_XFER   = 4'd3,
    CLS_BLOCK  = 4'd4,
    CLS_BRANCH = 4'd5,
    CLS_CPXFER = 4'd6,
    CLS_CPDATA = 4'd7,
    CLS_CPREG  = 4'd8,
    CLS_TRAP   = 4'd9
  } insn_class_e;

  typedef enum logic [2:0] {
    SHK_NONE = 3'd0,
    SHK_LSL  = 3'd1,
    SHK_LSR  = 3'd2,
    SHK_ASR  = 3'd3,
    SHK_ROR  = 3'd4,
    SHK_RRX  = 3'd5,
    SHK_REG  = 3'd6
  } shift_kind_e;

  localparam logic [3:0] COND_ALWAYS = 4'hE;

  localparam logic [5:0] MN_MUL    = 6'd16;
  localparam logic [5:0] MN_MLA    = 6'd17;
  localparam logic [5:0] MN_SWP    = 6'd18;
  localparam logic [5:0] MN_SWPB   = 6'd19;
  localparam logic [5:0] MN_XFER0  = 6'd20;
  localparam logic [5:0] MN_STM    = 6'd24;
  localparam logic [5:0] MN_LDM    = 6'd25;
  localparam logic [5:0] MN_B      = 6'd26;
  localparam logic [5:0] MN_BL     = 6'd27;
  localparam logic [5:0] MN_STC    = 6'd28;
  localparam logic [5:0] MN_LDC    = 6'd29;
  localparam logic [5:0] MN_CDP    = 6'd30;
  localparam logic [5:0] MN_MCR    = 6'd31;
  localparam logic [5:0] MN_MRC    = 6'd32;
  localparam logic [5:0] MN_SWI    = 6'd33;

  // Rotate an 8-bit value right by twice the 4-bit field.
  function automatic logic [31:0] expand_rot_imm(input logic [7:0] val, input logic [3:0] rot);
    logic [63:0] dbl;
    dbl = {24'd0, val, 24'd0, val};
    dbl = dbl >> {rot, 1'b0};
    return dbl[31:0];
  endfunction

  // Signed byte displacement of a word-granular 24-bit branch offset.
  function automatic logic signed [31:0] branch_disp(input logic [23:0] off);
    return {{6{off[23]}}, off, 2'b00};
  endfunction

endpackage

// File: rtl/insn_capture.sv
module insn_capture #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WORD_W-1:0] word_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              strobe_q
);

  logic take;
  assign take = valid_i && !stall_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q   <= '0;
      addr_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= take;
      if (take) begin
        word_q <= word_i;
        addr_q <= addr_i;
      end
    end
  end

  AST_STROBE_FROM_TAKE: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> $past(valid_i && !stall_i && !rst)); // R1

  AST_HOLD_WHEN_REFUSED: assert property (@(posedge clk) disable iff (rst)
    ($past(stall_i || !valid_i) && !$past(rst)) |-> ($stable(word_q) && $stable(addr_q))); // R2

endmodule

// File: rtl/insn_classifier.sv
module insn_classifier
  import insn_dec_pkg::*;
(
  input  logic [INSN_W-1:0] w,
  output insn_class_e       cls,
  output logic [5:0]        mnem,
  output logic [3:0]        cond,
  output logic              cond_always,
  output logic [3:0]        opcode,
  output logic              sflag,
  output logic [3:0]        rn,
  output logic [3:0]        rd,
  output logic [3:0]        rs,
  output logic [3:0]        rm,
  output logic              writes_rd,
  output logic              uses_rn
);

  // Overlapping patterns are exposed so the top can check their priority.
  logic swap_pat, mul_pat, is_compare, is_move;

  assign swap_pat = (w[27:23] == 5'b00010) && (w[21:20] == 2'b00) && (w[11:4] == 8'h09);
  assign mul_pat  = (w[27:22] == 6'b000000) && (w[7:4] == 4'b1001);

  assign cond   = w[31:28];
  assign opcode = w[24:21];
  assign sflag  = w[20];
  assign rn     = w[19:16];
  assign rd     = w[15:12];
  assign rs     = w[11:8];
  assign rm     = w[3:0];
  assign cond_always = (cond == COND_ALWAYS);

  always_comb begin
    if (swap_pat)                 cls = CLS_SWAP;
    else if (mul_pat)             cls = CLS_MUL;
    else if (w[27:26] == 2'b00)   cls = CLS_DATA;
    else if (w[27:26] == 2'b01)   cls = CLS_XFER;
    else if (w[27:25] == 3'b100)  cls = CLS_BLOCK;
    else if (w[27:25] == 3'b101)  cls = CLS_BRANCH;
    else if (w[27:25] == 3'b110)  cls = CLS_CPXFER;
    else if (w[27:24] == 4'b1110) cls = w[4] ? CLS_CPREG : CLS_CPDATA;
    else                          cls = CLS_TRAP;
  end

  always_comb begin
    unique case (cls)
      CLS_DATA:   mnem = {2'b00, opcode};
      CLS_MUL:    mnem = w[21] ? MN_MLA : MN_MUL;
      CLS_SWAP:   mnem = w[22] ? MN_SWPB : MN_SWP;
      CLS_XFER:   mnem = MN_XFER0 + {4'd0, w[20], w[22]};
      CLS_BLOCK:  mnem = w[20] ? MN_LDM : MN_STM;
      CLS_BRANCH: mnem = w[24] ? MN_BL : MN_B;
      CLS_CPXFER: mnem = w[20] ? MN_LDC : MN_STC;
      CLS_CPDATA: mnem = MN_CDP;
      CLS_CPREG:  mnem = w[20] ? MN_MRC : MN_MCR;
      default:    mnem = MN_SWI;
    endcase
  end

  assign is_compare = (opcode[3:2] == 2'b10);
  assign is_move    = (opcode == 4'd13) || (opcode == 4'd15);
  assign writes_rd  = (cls == CLS_DATA) && !is_compare;
  assign uses_rn    = (cls == CLS_DATA) && !is_move;

endmodule

// File: rtl/operand_expander.sv
module operand_expander
  import insn_dec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  insn_class_e       cls,
  input  logic [25:0]       w,
  input  logic [ADDR_W-1:0] pc,
  output logic              imm_valid,
  output logic [31:0]       imm,
  output shift_kind_e       shk,
  output logic [4:0]        shamt,
  output logic              link,
  output logic [ADDR_W-1:0] target,
  output logic              xbyte,
  output logic              xload,
  output logic [1:0]        bmode
);

  logic              is_data, is_br;
  logic signed [31:0] disp;

  assign is_data   = (cls == CLS_DATA);
  assign is_br     = (cls == CLS_BRANCH);

  assign imm_valid = is_data && w[25];
  assign imm       = imm_valid ? expand_rot_imm(w[7:0], w[11:8]) : 32'd0;

  always_comb begin
    shk   = SHK_NONE;
    shamt = 5'd0;
    if (is_data && !w[25]) begin
      if (w[4]) begin
        shk = SHK_REG;
      end else begin
        unique case (w[6:5])
          2'b00:   shk = (w[11:7] == 5'd0) ? SHK_NONE : SHK_LSL;
          2'b01:   shk = SHK_LSR;
          2'b10:   shk = SHK_ASR;
          default: shk = (w[11:7] == 5'd0) ? SHK_RRX : SHK_ROR;
        endcase
        if (shk != SHK_NONE && shk != SHK_RRX) shamt = w[11:7];
      end
    end
  end

  assign disp   = branch_disp(w[23:0]);
  assign link   = is_br && w[24];
  assign target = is_br ? (pc + ADDR_W'(disp)) : '0;

  assign xbyte  = (cls == CLS_XFER) && w[22];
  assign xload  = ((cls == CLS_XFER) || (cls == CLS_BLOCK)) && w[20];
  assign bmode  = (cls == CLS_BLOCK) ? w[24:23] : 2'b00;

endmodule

// File: rtl/insn_class_decoder.sv
module insn_class_decoder
  import insn_dec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall_i,
  input  logic              valid_i,
  input  logic [31:0]       insn_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              new_insn_o,
  output logic [31:0]       insn_o,
  output logic [ADDR_W-1:0] iaddr_o,
  output logic [3:0]        class_o,
  output logic [5:0]        mnem_o,
  output logic [3:0]        cond_o,
  output logic              cond_always_o,
  output logic [3:0]        opcode_o,
  output logic              sflag_o,
  output logic [3:0]        rn_o,
  output logic [3:0]        rd_o,
  output logic [3:0]        rs_o,
  output logic [3:0]        rm_o,
  output logic              writes_rd_o,
  output logic              uses_rn_o,
  output logic              imm_valid_o,
  output logic [31:0]       imm_o,
  output logic [2:0]        shift_kind_o,
  output logic [4:0]        shift_amt_o,
  output logic              branch_link_o,
  output logic [ADDR_W-1:0] branch_target_o,
  output logic              xfer_byte_o,
  output logic              xfer_load_o,
  output logic [1:0]        block_mode_o
);

  logic [INSN_W-1:0] word_q;
  insn_class_e       cls;
  shift_kind_e       shk;

  insn_capture #(.ADDR_W(ADDR_W), .WORD_W(INSN_W)) u_capture (
    .clk(clk), .rst(rst), .stall_i(stall_i), .valid_i(valid_i),
    .word_i(insn_i), .addr_i(addr_i),
    .word_q(word_q), .addr_q(iaddr_o), .strobe_q(new_insn_o)
  );

  insn_classifier u_class (
    .w(word_q), .cls(cls), .mnem(mnem_o), .cond(cond_o), .cond_always(cond_always_o),
    .opcode(opcode_o), .sflag(sflag_o), .rn(rn_o), .rd(rd_o), .rs(rs_o), .rm(rm_o),
    .writes_rd(writes_rd_o), .uses_rn(uses_rn_o)
  );

  operand_expander #(.ADDR_W(ADDR_W)) u_expand (
    .cls(cls), .w(word_q[25:0]), .pc(pc_i),
    .imm_valid(imm_valid_o), .imm(imm_o), .shk(shk), .shamt(shift_amt_o),
    .link(branch_link_o), .target(branch_target_o),
    .xbyte(xfer_byte_o), .xload(xfer_load_o), .bmode(block_mode_o)
  );

  assign insn_o       = word_q;
  assign class_o      = cls;
  assign shift_kind_o = shk;

  AST_SWAP_BEATS_DATA: assert property (@(posedge clk) disable iff (rst)
    u_class.swap_pat |-> (class_o == 4'd2)); // R5

  AST_DATA_MNEM_RANGE: assert property (@(posedge clk) disable iff (rst)
    (class_o == 4'd0) |-> (mnem_o < 6'd16)); // R6

  AST_IMM_ONLY_DATA: assert property (@(posedge clk) disable iff (rst)
    imm_valid_o |-> (class_o == 4'd0)); // R8

  AST_RRX_FROM_ROR: assert property (@(posedge clk) disable iff (rst)
    (shift_kind_o == 3'd5) |-> (insn_o[6:5] == 2'b11 && shift_amt_o == 5'd0)); // R9

  AST_BRANCH_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (class_o == 4'd5) |-> (branch_target_o[1:0] == pc_i[1:0])); // R10

  AST_COMPARE_NO_DEST: assert property (@(posedge clk) disable iff (rst)
    (opcode_o[3:2] == 2'b10) |-> !writes_rd_o); // R11

endmodule

// File: tb/tb_insn_class_decoder.sv
module tb_insn_class_decoder;

  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic stall_i = 1'b0, valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [ADDR_W-1:0] addr_i = '0, pc_i = '0;
  logic new_insn_o, cond_always_o, sflag_o, writes_rd_o, uses_rn_o, imm_valid_o;
  logic branch_link_o, xfer_byte_o, xfer_load_o;
  logic [31:0] insn_o, imm_o;
  logic [ADDR_W-1:0] iaddr_o, branch_target_o;
  logic [3:0] class_o, cond_o, opcode_o, rn_o, rd_o, rs_o, rm_o;
  logic [5:0] mnem_o;
  logic [2:0] shift_kind_o;
  logic [4:0] shift_amt_o;
  logic [1:0] block_mode_o;

  insn_class_decoder #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .stall_i(stall_i), .valid_i(valid_i), .insn_i(insn_i),
    .addr_i(addr_i), .pc_i(pc_i), .new_insn_o(new_insn_o), .insn_o(insn_o),
    .iaddr_o(iaddr_o), .class_o(class_o), .mnem_o(mnem_o), .cond_o(cond_o),
    .cond_always_o(cond_always_o), .opcode_o(opcode_o), .sflag_o(sflag_o),
    .rn_o(rn_o), .rd_o(rd_o), .rs_o(rs_o), .rm_o(rm_o), .writes_rd_o(writes_rd_o),
    .uses_rn_o(uses_rn_o), .imm_valid_o(imm_valid_o), .imm_o(imm_o),
    .shift_kind_o(shift_kind_o), .shift_amt_o(shift_amt_o),
    .branch_link_o(branch_link_o), .branch_target_o(branch_target_o),
    .xfer_byte_o(xfer_byte_o), .xfer_load_o(xfer_load_o), .block_mode_o(block_mode_o)
  );

  typedef struct packed {
    logic [31:0] w;
    logic [31:0] a;
    logic [31:0] pc;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] last_w = '0, last_a = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---- reference model, written from the requirements ----
  function automatic int m_class(input logic [31:0] w);
    if (w ==? 32'b????_00010_?_00_????_????_0000_1001_????) return 2;
    if (w ==? 32'b????_000000_??????????????_1001_????) return 1;
    case (w[27:25])
      3'b000, 3'b001: return 0;
      3'b010, 3'b011: return 3;
      3'b100: return 4;
      3'b101: return 5;
      3'b110: return 6;
      default: return (w[24] == 1'b0) ? (w[4] ? 8 : 7) : 9;
    endcase
  endfunction

  function automatic int m_mnem(input logic [31:0] w);
    case (m_class(w))
      0: return int'(w[24:21]);
      1: return 16 + int'(w[21]);
      2: return 18 + int'(w[22]);
      3: return 20 + 2 * int'(w[20]) + int'(w[22]);
      4: return 24 + int'(w[20]);
      5: return 26 + int'(w[24]);
      6: return 28 + int'(w[20]);
      7: return 30;
      8: return 31 + int'(w[20]);
      default: return 33;
    endcase
  endfunction

  function automatic logic [31:0] m_imm(input logic [31:0] w);
    logic [31:0] x;
    int r;
    if (!(m_class(w) == 0 && w[25])) return 32'd0;
    x = {24'd0, w[7:0]};
    r = 2 * int'(w[11:8]);
    return (x >> r) | (x << (32 - r));
  endfunction

  function automatic int m_shk(input logic [31:0] w);
    int amt;
    amt = int'(w[11:7]);
    if (m_class(w) != 0 || w[25]) return 0;
    if (w[4]) return 6;
    case (w[6:5])
      2'd0: return (amt == 0) ? 0 : 1;
      2'd1: return 2;
      2'd2: return 3;
      default: return (amt == 0) ? 5 : 4;
    endcase
  endfunction

  function automatic logic [31:0] m_target(input logic [31:0] w, input logic [31:0] pc);
    logic signed [31:0] s;
    if (m_class(w) != 5) return 32'd0;
    s = {w[23:0], 8'd0};
    s = s >>> 6;
    return pc + s;
  endfunction

  // ---- driver ----
  task automatic drive(input logic [31:0] w, input logic [31:0] a, input logic [31:0] p,
                       input bit v, input bit s);
    @(negedge clk);
    insn_i = w; addr_i = a; pc_i = p; valid_i = v; stall_i = s;
    if (v && !s && !rst) begin
      q.push_back('{w: w, a: a, pc: p});
      last_w = w; last_a = a;
    end
  endtask

  task automatic refused(input logic [31:0] w, input bit v, input bit s);
    drive(w, 32'hDEAD_0000, 32'h0000_4000, v, s);
    @(posedge clk); #1;
    chk(new_insn_o == 1'b0, "R2 strobe after refused offer", {31'd0, new_insn_o}, 32'd0);
    chk(insn_o == last_w, "R2 latched word held", insn_o, last_w);
    chk(iaddr_o == last_a, "R2 latched address held", iaddr_o, last_a);
  endtask

  // ---- monitor / scoreboard ----
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst && new_insn_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1 strobe without accepted word", insn_o, 32'd0);
        end else begin
          item_t it;
          int sk;
          it = q.pop_front();
          sk = m_shk(it.w);
          chk(insn_o == it.w, "R1 latched word", insn_o, it.w);
          chk(iaddr_o == it.a, "R1 latched address", iaddr_o, it.a);
          chk(int'(class_o) == m_class(it.w), "R4 R5 class", {28'd0, class_o}, m_class(it.w));
          chk(int'(mnem_o) == m_mnem(it.w), "R6 mnemonic", {26'd0, mnem_o}, m_mnem(it.w));
          chk({cond_o, opcode_o, sflag_o, rn_o, rd_o, rs_o, rm_o, cond_always_o} ==
              {it.w[31:28], it.w[24:21], it.w[20], it.w[19:16], it.w[15:12], it.w[11:8],
               it.w[3:0], it.w[31:28] == 4'hE},
              "R7 fields", {cond_o, opcode_o, rn_o, rd_o, rs_o, rm_o, 8'd0}, it.w);
          chk(imm_valid_o == (m_class(it.w) == 0 && it.w[25]), "R8 immediate valid",
              {31'd0, imm_valid_o}, {31'd0, (m_class(it.w) == 0 && it.w[25])});
          chk(imm_o == m_imm(it.w), "R8 immediate value", imm_o, m_imm(it.w));
          chk(int'(shift_kind_o) == sk, "R9 shift kind", {29'd0, shift_kind_o}, sk);
          chk(shift_amt_o == ((sk >= 1 && sk <= 4) ? it.w[11:7] : 5'd0), "R9 shift amount",
              {27'd0, shift_amt_o}, (sk >= 1 && sk <= 4) ? {27'd0, it.w[11:7]} : 32'd0);
          chk(branch_target_o == m_target(it.w, it.pc), "R10 branch target",
              branch_target_o, m_target(it.w, it.pc));
          chk(branch_link_o == (m_class(it.w) == 5 && it.w[24]), "R10 link",
              {31'd0, branch_link_o}, {31'd0, (m_class(it.w) == 5 && it.w[24])});
          chk(writes_rd_o == (m_class(it.w) == 0 && !(it.w[24:21] inside {[4'd8:4'd11]})),
              "R11 writes destination", {31'd0, writes_rd_o}, 32'd0);
          chk(uses_rn_o == (m_class(it.w) == 0 && it.w[24:21] != 4'd13 && it.w[24:21] != 4'd15),
              "R11 uses first operand", {31'd0, uses_rn_o}, 32'd0);
          chk({xfer_byte_o, xfer_load_o, block_mode_o} ==
              {m_class(it.w) == 3 && it.w[22], (m_class(it.w) inside {3, 4}) && it.w[20],
               (m_class(it.w) == 4) ? it.w[24:23] : 2'b00},
              "R12 transfer fields", {28'd0, xfer_byte_o, xfer_load_o, block_mode_o}, it.w);
        end
      end
    end
  end

  // ---- watchdog ----
  initial begin
    #(200000 * 4);
    if (!done) begin
      chk(1'b0, "R1 watchdog expired", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // ---- stimulus ----
  localparam int NDIR = 34;
  logic [31:0] dir_words [NDIR] = '{
    32'hE3A000AB, 32'hE3A00CFF, 32'hE3A00FFF, 32'hE3A004FF, 32'hE2811001,
    32'hE1A00000, 32'hE1A00060, 32'hE1A00461, 32'hE1A00311, 32'hE1A00140,
    32'hE1A001C2, 32'hE1500001, 32'h01100002, 32'hE1E00001, 32'hE0010392,
    32'hE0210392, 32'hE1012092, 32'hE1412092, 32'hE1212092, 32'hE5910004,
    32'hE5C10004, 32'hE4D10001, 32'hE8BD000F, 32'hE92D4000, 32'hEAFFFFFE,
    32'hEB000010, 32'h1A800000, 32'hED910100, 32'hEC810100, 32'hEE010100,
    32'hEE110F10, 32'hEE010F10, 32'hEF123456, 32'hFF000000
  };

  initial begin
    logic [31:0] seed;
    seed = 32'h1234_5678;

    repeat (3) @(posedge clk);
    #1;
    // R3 reset state
    chk(new_insn_o == 1'b0, "R3 strobe in reset", {31'd0, new_insn_o}, 32'd0);
    chk(insn_o == 32'd0, "R3 word cleared", insn_o, 32'd0);
    chk(iaddr_o == 32'd0, "R3 address cleared", iaddr_o, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NDIR; i++) begin
      drive(dir_words[i], 32'h0000_1000 + 32'(i * 4), 32'h0080_0000 + 32'(i * 8), 1'b1, 1'b0);
    end
    // refusals right after an accept (R2)
    refused(32'hE3A0F0FF, 1'b1, 1'b1);
    refused(32'hEAFFFFFF, 1'b0, 1'b0);
    drive(32'hE2811001, 32'h0000_2000, 32'h0, 1'b1, 1'b0);
    refused(32'hE1A00060, 1'b1, 1'b1);

    // mixed random stream with random stall and valid
    for (int i = 0; i < 600; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      drive(seed, {seed[15:0], seed[31:16]} & 32'hFFFF_FFFC, seed ^ 32'h5A5A_A5A0,
            seed[3:0] != 4'd0, seed[7:5] == 3'd0);
    end
    drive(32'h0, 32'h0, 32'h0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    chk(q.size() == 0, "R1 every accepted word strobed", q.size(), 32'd0);

    // mid-run reset while a word is offered (R3)
    @(negedge clk);
    rst = 1'b1; valid_i = 1'b1; stall_i = 1'b0; insn_i = 32'hE1A00000;
    @(posedge clk); #1;
    chk(insn_o == 32'd0, "R3 word cleared mid-run", insn_o, 32'd0);
    chk(new_insn_o == 1'b0, "R3 strobe low mid-run", {31'd0, new_insn_o}, 32'd0);
    @(negedge clk);
    valid_i = 1'b0; rst = 1'b0;
    repeat (2) @(posedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule